// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the single-word reservation behind an atomic read-modify-write loop. A load-linked request records a reservation on the word it addresses. A later conditional store writes its data to memory only if that reservation is still intact and covers the same word. The block reports the 0/1 outcome for the destination register and gives a memory write strobe with the aligned address and data. Each request carries a base register value, a 9-bit signed offset split into a 4-bit high part and a 5-bit low part, and store data.

Remote writes to the reserved word and exceptions come in as sideband pulses, and both break the reservation. An unaligned effective address raises an address-error flag and cancels the request. Address translation, caches and instruction decode are outside the block. All outputs are registered and appear one clock after the request.

Top module: `llsc_monitor`

## Requirements
- R1: The effective address is `base_i` plus the sign extension of the 9-bit offset `{imm_hi_i, imm_lo_i}` (imm_hi_i holds offset bits 8..5, and bit 8 is the sign). On a memory write, `mem_addr_o` carries that address with bits 1..0 forced to zero, and `mem_wdata_o` carries the store data.
- R2: A conditional store (`req_op_i` = 2'b10) asserts `mem_we_o` only if the reservation is set and effective-address bits 31..2 equal the reserved word address.
- R3: Every aligned conditional store asserts `status_we_o`. `status_o` is 1 when the write was performed and 0 when memory was left alone.
- R4: Every conditional store clears the reservation, whether it succeeds, fails or mismatches.
- R5: A load, load-linked or conditional store whose effective address has a non-zero bit 1 or 0 asserts `addr_err_o`. It writes no memory and no status, and it clears the reservation.
- R6: An aligned load-linked (`req_op_i` = 2'b01) sets the reservation and records effective-address bits 31..2. This replaces any older reservation.
- R7: An aligned ordinary load (`req_op_i` = 2'b00) leaves the reservation unchanged, even when it hits the reserved word.
- R8: `inval_i` or `excp_i` clears the reservation. In the same cycle as a conditional store, the store fails. In the same cycle as a load-linked, the load-linked still sets a fresh reservation.
- R9: Reset clears the reservation and drives every output strobe to 0. Results appear on the clock edge that samples the request. A cycle with `req_valid_i` low, or with `req_op_i` = 2'b11, drives all strobes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 00 load, 01 load-linked, 10 conditional store, 11 none |
| base_i | input | 32 | Base register value |
| imm_hi_i | input | 4 | Offset bits 8..5 |
| imm_lo_i | input | 5 | Offset bits 4..0 |
| wdata_i | input | 32 | Store data |
| inval_i | input | 1 | Remote write to the reserved word |
| excp_i | input | 1 | Exception taken |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Aligned write address |
| mem_wdata_o | output | 32 | Write data |
| status_we_o | output | 1 | Destination status write |
| status_o | output | 1 | 1 when the store succeeded |
| addr_err_o | output | 1 | Unaligned effective address |

## Verification
The sensitive overlap is a clear event (`inval_i` or `excp_i`) landing in the same cycle as a conditional store or a load-linked. The first must make the store fail. The second must still leave a valid reservation. Directed sequences drive each overlap and then follow it with a conditional store to the same word, so the reservation state can be read through `status_o` and `mem_we_o`. Random traffic also raises the clear inputs at random against a reference model that applies clears before the request of the same cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_LL   = 2'b01,
    OP_SC   = 2'b10,
    OP_NONE = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_ea_gen.sv
module llsc_ea_gen #(
  parameter int XLEN     = 32,
  parameter int IMM_HI_W = 4,
  parameter int IMM_LO_W = 5
) (
  input  logic [XLEN-1:0]     base_i,
  input  logic [IMM_HI_W-1:0] imm_hi_i,
  input  logic [IMM_LO_W-1:0] imm_lo_i,
  output logic [XLEN-1:0]     ea_o,
  output logic                misaligned_o
);
  localparam int IMM_W = IMM_HI_W + IMM_LO_W;

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_sx;

  assign imm          = {imm_hi_i, imm_lo_i};
  assign imm_sx       = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign ea_o         = base_i + imm_sx;
  assign misaligned_o = |ea_o[1:0];
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int TAG_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o
);
  // set wins: clears of this cycle are ordered before the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tag_o <= '0;
    end else begin
      if (set_i) begin
        vld_o <= 1'b1;
        tag_o <= tag_i;
      end else if (clr_i || kill_i) begin
        vld_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
  import llsc_pkg::*;
#(
  parameter int TAG_W = 30
) (
  input  logic             valid_i,
  input  llsc_op_e         op_i,
  input  logic             misaligned_i,
  input  logic             kill_i,
  input  logic             resv_vld_i,
  input  logic [TAG_W-1:0] resv_tag_i,
  input  logic [TAG_W-1:0] ea_tag_i,
  output logic             we_o,
  output logic             status_we_o,
  output logic             err_o,
  output logic             set_o,
  output logic             clr_o
);
  logic active, sc_ok, resv_live;

  always_comb begin
    active      = valid_i && (op_i != OP_NONE);
    err_o       = active && misaligned_i;
    sc_ok       = valid_i && (op_i == OP_SC) && !misaligned_i;
    resv_live   = resv_vld_i && !kill_i;
    we_o        = sc_ok && resv_live && (resv_tag_i == ea_tag_i);
    status_we_o = sc_ok;
    set_o       = valid_i && (op_i == OP_LL) && !misaligned_i;
    clr_o       = sc_ok || err_o;
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_HI_W = 4,
  parameter int IMM_LO_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [1:0]          req_op_i,
  input  logic [XLEN-1:0]     base_i,
  input  logic [IMM_HI_W-1:0] imm_hi_i,
  input  logic [IMM_LO_W-1:0] imm_lo_i,
  input  logic [XLEN-1:0]     wdata_i,
  input  logic                inval_i,
  input  logic                excp_i,
  output logic                mem_we_o,
  output logic [XLEN-1:0]     mem_addr_o,
  output logic [XLEN-1:0]     mem_wdata_o,
  output logic                status_we_o,
  output logic                status_o,
  output logic                addr_err_o
);
  localparam int TAG_W = XLEN - 2;

  logic [XLEN-1:0]  ea;
  logic             misaligned;
  logic             kill;
  logic             resv_vld;
  logic [TAG_W-1:0] resv_tag;
  logic             we_d, swe_d, err_d, set_d, clr_d;
  llsc_op_e         op;

  assign op   = llsc_op_e'(req_op_i);
  assign kill = inval_i || excp_i;

  llsc_ea_gen #(.XLEN(XLEN), .IMM_HI_W(IMM_HI_W), .IMM_LO_W(IMM_LO_W)) u_ea (
    .base_i       (base_i),
    .imm_hi_i     (imm_hi_i),
    .imm_lo_i     (imm_lo_i),
    .ea_o         (ea),
    .misaligned_o (misaligned)
  );

  llsc_decide #(.TAG_W(TAG_W)) u_dec (
    .valid_i      (req_valid_i),
    .op_i         (op),
    .misaligned_i (misaligned),
    .kill_i       (kill),
    .resv_vld_i   (resv_vld),
    .resv_tag_i   (resv_tag),
    .ea_tag_i     (ea[XLEN-1:2]),
    .we_o         (we_d),
    .status_we_o  (swe_d),
    .err_o        (err_d),
    .set_o        (set_d),
    .clr_o        (clr_d)
  );

  llsc_resv #(.TAG_W(TAG_W)) u_resv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kill_i (kill),
    .set_i  (set_d),
    .clr_i  (clr_d),
    .tag_i  (ea[XLEN-1:2]),
    .vld_o  (resv_vld),
    .tag_o  (resv_tag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      status_we_o <= 1'b0;
      status_o    <= 1'b0;
      addr_err_o  <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o    <= we_d;
      status_we_o <= swe_d;
      status_o    <= we_d;
      addr_err_o  <= err_d;
      if (we_d) begin
        mem_addr_o  <= {ea[XLEN-1:2], 2'b00};
        mem_wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [1:0]      req_op_i,
  input logic            inval_i,
  input logic            excp_i,
  input logic [XLEN-1:0] ea,
  input logic            resv_vld,
  input logic            mem_we_o,
  input logic            status_we_o,
  input logic            status_o,
  input logic            addr_err_o
);
  a_r2_we_needs_resv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(resv_vld));

  a_r3_status_tracks_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_we_o |-> (status_o == mem_we_o));

  a_r3_we_has_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> status_we_o);

  a_r4_sc_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b10) |=> !resv_vld);

  a_r5_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> (!mem_we_o && !status_we_o));

  a_r7_load_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b00 && ea[1:0] == 2'b00 &&
     !inval_i && !excp_i && resv_vld) |=> resv_vld);

  a_r8_kill_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((inval_i || excp_i) && !(req_valid_i && req_op_i == 2'b01)) |=> !resv_vld);
endmodule

bind llsc_monitor llsc_monitor_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .inval_i     (inval_i),
  .excp_i      (excp_i),
  .ea          (ea),
  .resv_vld    (resv_vld),
  .mem_we_o    (mem_we_o),
  .status_we_o (status_we_o),
  .status_o    (status_o),
  .addr_err_o  (addr_err_o)
);

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b11;
  logic [31:0] base = '0;
  logic [3:0]  imm_hi = '0;
  logic [4:0]  imm_lo = '0;
  logic [31:0] wdata = '0;
  logic        inval = 1'b0;
  logic        excp = 1'b0;
  logic        mem_we, status_we, status, addr_err;
  logic [31:0] mem_addr, mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  bit        m_vld = 1'b0;
  bit [29:0] m_tag = '0;

  always #4 clk = ~clk;

  llsc_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .base_i(base), .imm_hi_i(imm_hi), .imm_lo_i(imm_lo), .wdata_i(wdata),
    .inval_i(inval), .excp_i(excp), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .status_we_o(status_we), .status_o(status),
    .addr_err_o(addr_err)
  );

  function automatic logic [31:0] calc_ea(input logic [31:0] b, input logic [8:0] imm);
    return b + {{23{imm[8]}}, imm};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic v, input logic [1:0] op,
                       input logic [31:0] b, input logic [8:0] imm, input logic [31:0] wd,
                       input logic inv, input logic ex);
    logic [31:0] ea;
    bit mis, sc_ok, live, e_we, e_err;
    @(negedge clk);
    req_valid = v; req_op = op; base = b; imm_hi = imm[8:5]; imm_lo = imm[4:0];
    wdata = wd; inval = inv; excp = ex;
    ea    = calc_ea(b, imm);
    mis   = |ea[1:0];
    live  = m_vld && !(inv || ex);
    sc_ok = v && op == 2'b10 && !mis;
    e_we  = sc_ok && live && (ea[31:2] == m_tag);
    e_err = v && op != 2'b11 && mis;
    @(posedge clk);
    #1;
    chk({tag, ":R2"}, "mem_we", 32'(mem_we), 32'(e_we));
    chk({tag, ":R3"}, "status_we", 32'(status_we), 32'(sc_ok));
    chk({tag, ":R3"}, "status", 32'(status), 32'(e_we));
    chk({tag, ":R5"}, "addr_err", 32'(addr_err), 32'(e_err));
    if (e_we) begin
      chk({tag, ":R1"}, "mem_addr", mem_addr, {ea[31:2], 2'b00});
      chk({tag, ":R1"}, "mem_wdata", mem_wdata, wd);
    end
    // model update: clears first, then request
    if (inv || ex) m_vld = 1'b0;
    if (v && op != 2'b11) begin
      if (mis) m_vld = 1'b0;
      else if (op == 2'b01) begin m_vld = 1'b1; m_tag = ea[31:2]; end
      else if (op == 2'b10) m_vld = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ll_b;
    logic [8:0]  ll_i;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9", "rst mem_we", 32'(mem_we), 0);
    chk("R9", "rst status_we", 32'(status_we), 0);
    chk("R9", "rst addr_err", 32'(addr_err), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: idle and op 11 give nothing
    apply("R9", 1'b0, 2'b10, 32'h100, 9'h0, 32'h1, 1'b0, 1'b0);
    apply("R9", 1'b1, 2'b11, 32'h101, 9'h0, 32'h1, 1'b0, 1'b0);
    // R6/R2: LL then SC succeeds; R4: second SC fails
    apply("R6", 1'b1, 2'b01, 32'h2000, 9'h010, 32'h0, 1'b0, 1'b0);
    apply("R2", 1'b1, 2'b10, 32'h2000, 9'h010, 32'hCAFE_0001, 1'b0, 1'b0);
    apply("R4", 1'b1, 2'b10, 32'h2000, 9'h010, 32'hCAFE_0002, 1'b0, 1'b0);
    // R1: negative offset forms same word
    apply("R1", 1'b1, 2'b01, 32'h3000, 9'h1FC, 32'h0, 1'b0, 1'b0);
    apply("R1", 1'b1, 2'b10, 32'h2FF0, 9'h00C, 32'h1234_5678, 1'b0, 1'b0);
    // R7: load to reserved word keeps reservation
    apply("R7", 1'b1, 2'b01, 32'h4000, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R7", 1'b1, 2'b00, 32'h4000, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R7", 1'b1, 2'b10, 32'h4000, 9'h0, 32'h7777, 1'b0, 1'b0);
    // R4: mismatched SC fails and still clears
    apply("R4", 1'b1, 2'b01, 32'h5000, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R4", 1'b1, 2'b10, 32'h5004, 9'h0, 32'h1, 1'b0, 1'b0);
    apply("R4", 1'b1, 2'b10, 32'h5000, 9'h0, 32'h2, 1'b0, 1'b0);
    // R6: newer LL replaces older
    apply("R6", 1'b1, 2'b01, 32'h6000, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R6", 1'b1, 2'b01, 32'h6100, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R6", 1'b1, 2'b10, 32'h6000, 9'h0, 32'h3, 1'b0, 1'b0);
    // R8: invalidate between LL and SC
    apply("R8", 1'b1, 2'b01, 32'h7000, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R8", 1'b0, 2'b11, 32'h0, 9'h0, 32'h0, 1'b1, 1'b0);
    apply("R8", 1'b1, 2'b10, 32'h7000, 9'h0, 32'h4, 1'b0, 1'b0);
    // R8: exception same cycle as SC
    apply("R8", 1'b1, 2'b01, 32'h7100, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R8", 1'b1, 2'b10, 32'h7100, 9'h0, 32'h5, 1'b0, 1'b1);
    // R8: invalidate same cycle as LL, LL still holds
    apply("R8", 1'b1, 2'b01, 32'h7200, 9'h0, 32'h0, 1'b1, 1'b0);
    apply("R8", 1'b1, 2'b10, 32'h7200, 9'h0, 32'h6, 1'b0, 1'b0);
    // R5: unaligned SC, then unaligned load clears reservation
    apply("R5", 1'b1, 2'b01, 32'h8000, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R5", 1'b1, 2'b10, 32'h8000, 9'h002, 32'h7, 1'b0, 1'b0);
    apply("R5", 1'b1, 2'b01, 32'h8000, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R5", 1'b1, 2'b00, 32'h8001, 9'h0, 32'h0, 1'b0, 1'b0);
    apply("R5", 1'b1, 2'b10, 32'h8000, 9'h0, 32'h8, 1'b0, 1'b0);

    // constrained random
    ll_b = 32'h9000; ll_i = 9'h0;
    for (int k = 0; k < 4000; k++) begin
      logic [1:0]  op;
      logic [31:0] b;
      logic [8:0]  im;
      op = 2'($urandom % 4);
      b  = 32'h9000 + ((32'($urandom % 4)) << 2);
      im = 9'({$urandom} % 512) & 9'h1F8;
      if ($urandom % 8 == 0) im[1:0] = 2'($urandom % 4);
      if (op == 2'b01) begin ll_b = b; ll_i = im; end
      else if ($urandom % 2 == 0) begin b = ll_b; im = ll_i; end
      apply("RND", ($urandom % 8) != 0, op, b, im, $urandom,
            ($urandom % 16) == 0, ($urandom % 16) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule